// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This host-side controller decides how a program or erase operation in an external flash bank ended, after the command sequence has been written. A start pulse captures the polling address, the expected data word and the method to use. The controller then issues read cycles on a request/acknowledge bus and interprets the returned status bits until it can report success or failure. Nothing about the flash itself is modelled here.

Two methods are supported. Data polling compares the ready bit (bit 7) of each read with bit 7 of the expected data. Toggle polling compares the toggle bit (bit 6) of consecutive reads. In both methods the timeout bit (bit 5) does not cause a failure on its own. It triggers one more confirmation step, because the status bit and the timeout bit can change in the same read. When failure is confirmed, the controller pulses a request to write the reset command, which returns the bank to array reads. For an erase poll the expected word is all ones, so completion means bit 7 reads 1. For chip erase, any address in an unprotected sector can be used.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset `rd_req_o`, `busy_o`, `done_o`, `pass_o`, `fail_o` and `rst_cmd_o` are all low.
- R2: A start captures `addr_i`. Every read request presents that address. `rd_req_o` stays high until `rd_ack_i`, and `rd_data_i` is taken in the acknowledge cycle. `rd_req_o` is low whenever `done_o` is high.
- R3: In data-poll mode (`mode_i`=0), a read whose bit 7 equals bit 7 of `exp_data_i` ends the poll with pass. A read that mismatches and has bit 5 low causes another read.
- R4: In data-poll mode, a mismatching read with bit 5 high causes exactly one more read. That read passes if its bit 7 matches and fails otherwise.
- R5: In toggle mode (`mode_i`=1), two reads are compared. If bit 6 is equal in consecutive reads, the poll ends with pass. If bit 6 differs and bit 5 is low, the latest read becomes the reference and one further read is made.
- R6: In toggle mode, a read whose bit 6 differs and whose bit 5 is high starts a confirmation pair of two fresh reads. If bit 6 is still toggling across that pair, the poll fails. Otherwise it passes.
- R7: On failure, `rst_cmd_o` pulses high for exactly one cycle, in the first cycle that `done_o` is high. It never pulses on pass.
- R8: `done_o` and exactly one of `pass_o`/`fail_o` stay high from the end of a poll until the next start. The cycle after a start, they are cleared.
- R9: A start while `busy_o` is high is ignored. The captured address, the method and the result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a poll (single-cycle pulse) |
| mode_i | input | 1 | 0 = data polling, 1 = toggle polling |
| addr_i | input | ADDR_W | Address to poll |
| exp_data_i | input | DATA_W | Data expected once the operation is complete |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` valid |
| rd_data_i | input | DATA_W | Returned read data |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Result available |
| pass_o | output | 1 | Operation completed |
| fail_o | output | 1 | Operation failed (timeout confirmed) |
| rst_cmd_o | output | 1 | One-cycle request to write the reset command |

## Verification
The bench builds the block with its default parameters: a 16-bit data bus, a 20-bit address, and status bit positions 7, 6 and 5. Each poll is fed from a per-read status script, with acknowledges that arrive at random after one or more cycles. This exercises the cases where the timeout bit and the status bit change together, as well as recheck reads that land on either outcome. Starts injected while a poll is running, together with exact counts of reads per poll, expose any premature restart or any extra or missing read.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DP_RD,
    ST_DP_CHK,
    ST_TG_RD0,
    ST_TG_RD1,
    ST_PASS,
    ST_FAIL
  } poll_st_e;
endpackage

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
  parameter int DATA_W  = 16,
  parameter int RDY_BIT = 7,
  parameter int TOG_BIT = 6,
  parameter int TMO_BIT = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              exp_bit_i,
  input  logic              prev_tog_i,
  output logic              rdy_match_o,
  output logic              tog_same_o,
  output logic              tmo_o,
  output logic              tog_o
);
  logic unused_data;
  assign unused_data = ^data_i;

  assign rdy_match_o = data_i[RDY_BIT] == exp_bit_i;
  assign tog_o       = data_i[TOG_BIT];
  assign tog_same_o  = data_i[TOG_BIT] == prev_tog_i;
  assign tmo_o       = data_i[TMO_BIT];
endmodule

// File: rtl/flash_poll_addr.sv
module flash_poll_addr #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 20,
  parameter int RDY_BIT = 7,
  parameter int TOG_BIT = 6,
  parameter int TMO_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_data_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              rst_cmd_o
);
  poll_st_e st_q, st_d;
  logic     exp_q, prev_q, rechk_q, rst_cmd_q;
  logic     load, rdy_match, tog_same, tmo, tog;
  logic     unused_exp;

  assign unused_exp = ^exp_data_i;

  flash_poll_eval #(
    .DATA_W(DATA_W), .RDY_BIT(RDY_BIT), .TOG_BIT(TOG_BIT), .TMO_BIT(TMO_BIT)
  ) u_eval (
    .data_i     (rd_data_i),
    .exp_bit_i  (exp_q),
    .prev_tog_i (prev_q),
    .rdy_match_o(rdy_match),
    .tog_same_o (tog_same),
    .tmo_o      (tmo),
    .tog_o      (tog)
  );

  flash_poll_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .addr_i(addr_i),
    .addr_o(rd_addr_o)
  );

  assign busy_o   = !(st_q inside {ST_IDLE, ST_PASS, ST_FAIL});
  assign rd_req_o = busy_o;
  assign done_o   = st_q inside {ST_PASS, ST_FAIL};
  assign pass_o   = st_q == ST_PASS;
  assign fail_o   = st_q == ST_FAIL;
  assign rst_cmd_o = rst_cmd_q;
  assign load     = start_i && !busy_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_PASS, ST_FAIL:
        if (start_i) st_d = mode_i ? ST_TG_RD0 : ST_DP_RD;
      ST_DP_RD:
        if (rd_ack_i) begin
          if (rdy_match) st_d = ST_PASS;
          else if (tmo)  st_d = ST_DP_CHK;
        end
      ST_DP_CHK:
        if (rd_ack_i) st_d = rdy_match ? ST_PASS : ST_FAIL;
      ST_TG_RD0:
        if (rd_ack_i) st_d = ST_TG_RD1;
      ST_TG_RD1:
        if (rd_ack_i) begin
          if (tog_same)     st_d = ST_PASS;
          else if (rechk_q) st_d = ST_FAIL;
          else if (tmo)     st_d = ST_TG_RD0;
        end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      exp_q     <= 1'b0;
      prev_q    <= 1'b0;
      rechk_q   <= 1'b0;
      rst_cmd_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      rst_cmd_q <= (st_d == ST_FAIL) && (st_q != ST_FAIL);
      if (load) begin
        exp_q   <= exp_data_i[RDY_BIT];
        rechk_q <= 1'b0;
      end
      if (rd_ack_i && (st_q == ST_TG_RD0 || st_q == ST_TG_RD1)) prev_q <= tog;
      if (rd_ack_i && st_q == ST_TG_RD1 && !tog_same && tmo) rechk_q <= 1'b1;
    end
  end

  p_one_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o ^ fail_o));
  p_hold_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(pass_o)));
  p_cmd_on_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_o |-> fail_o);
  p_cmd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_o |=> !rst_cmd_o);
  p_no_req_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
  p_req_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  p_addr_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(rd_addr_o)));
endmodule

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int SL = 24;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0, mode = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic          rd_req, rd_ack = 0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          busy, done, pass, fail, rst_cmd;

  int checks = 0, errors = 0;
  logic [DW-1:0] script [SL];
  int rd_idx = 0;

  always #2 clk = ~clk;

  flash_poll_ctrl u_flash_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .addr_i(addr), .exp_data_i(exp_data), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fail_o(fail),
    .rst_cmd_o(rst_cmd)
  );

  function automatic logic [DW-1:0] get_rd(int i);
    return (i < SL) ? script[i] : script[SL-1];
  endfunction

  // expected outcome per requirements R3-R6; returns pass, sets read count
  function automatic bit model(bit m, bit e, output int nrd);
    logic [DW-1:0] d, p;
    bit rc;
    nrd = 0;
    if (!m) begin
      forever begin
        d = get_rd(nrd); nrd++;
        if (d[7] == e) return 1;
        if (d[5]) begin
          d = get_rd(nrd); nrd++;
          return d[7] == e;
        end
      end
    end else begin
      rc = 0;
      p = get_rd(nrd); nrd++;
      forever begin
        d = get_rd(nrd); nrd++;
        if (d[6] == p[6]) return 1;
        if (rc) return 0;
        if (d[5]) begin
          rc = 1;
          p = get_rd(nrd); nrd++;
        end else p = d;
      end
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rd_req && ($urandom_range(0, 1) == 1)) begin
      rd_ack  <= 1;
      rd_data <= get_rd(rd_idx);
      rd_idx  <= rd_idx + 1;
    end else begin
      rd_ack  <= 0;
      rd_data <= $urandom;
    end
  end

  task automatic run_poll(bit m, bit e, logic [AW-1:0] a, bit intrude);
    int  nrd, cyc, ncmd;
    bit  exp_pass, addr_ok;
    exp_pass = model(m, e, nrd);
    @(negedge clk);
    rd_idx   = 0;
    start    = 1; mode = m; addr = a;
    exp_data = e ? 16'hFFFF : 16'h0000;
    @(negedge clk);
    start = 0;
    mode  = $urandom; addr = $urandom; exp_data = $urandom;
    chk(!done && !pass && !fail, "R8", "result cleared after start", done, 0);
    cyc = 0; ncmd = 0; addr_ok = 1;
    forever begin
      if (intrude && cyc == 2) start = 1;
      @(negedge clk);
      start = 0;
      cyc++;
      if (rst_cmd) ncmd++;
      if (rd_req && rd_addr != a) addr_ok = 0;
      if (done || cyc > 400) break;
    end
    chk(done, "R2", "poll completes", done, 1);
    chk(addr_ok, "R2", "read address", rd_addr, a);
    chk(rd_idx == nrd, m ? "R5" : "R3", "read count", rd_idx, nrd);
    chk(pass == exp_pass && fail == !exp_pass, m ? "R6" : "R4", "pass flag", pass, exp_pass);
    chk(ncmd == (exp_pass ? 0 : 1), "R7", "reset command pulses", ncmd, exp_pass ? 0 : 1);
    if (intrude) chk(rd_addr == a && rd_idx == nrd, "R9", "start ignored while busy", rd_addr, a);
    repeat (3) @(negedge clk);
    chk(done && pass == exp_pass && !rd_req, "R8", "result held", pass, exp_pass);
  endtask

  task automatic fill_rand(bit e);
    bit t;
    t = $urandom;
    for (int i = 0; i < SL; i++) begin
      script[i] = $urandom;
      script[i][7] = ($urandom_range(0, 4) == 0) ? e : ~e;
      if ($urandom_range(0, 4) != 0) t = ~t;
      script[i][6] = t;
      script[i][5] = ($urandom_range(0, 3) == 0);
    end
    script[SL-1] = script[SL-2];
    script[SL-1][7] = e;
  endtask

  task automatic fill_const(logic [DW-1:0] v);
    for (int i = 0; i < SL; i++) script[i] = v;
  endtask

  initial begin
    void'($urandom(32'h1234));
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!rd_req && !busy && !done && !pass && !fail && !rst_cmd, "R1",
            "reset state", {rd_req, busy, done, pass, fail, rst_cmd}, 0);
        rst_n = 1;
        // R3 immediate data-poll match (erase, bit7=1)
        fill_const(16'h0080); run_poll(0, 1, 20'h1_2345, 0);
        // R4 timeout then recheck matches
        fill_const(16'h0080); script[0] = 16'h0020; run_poll(0, 1, 20'h0_0100, 0);
        // R4 timeout then recheck mismatches -> fail
        fill_const(16'h0080); script[0] = 16'h0020; script[1] = 16'h0020;
        run_poll(0, 1, 20'h0_0200, 0);
        // R5 toggle stopped at once
        fill_const(16'h0040); run_poll(1, 1, 20'h0_0300, 0);
        // R6 toggling with timeout, still toggling in confirmation -> fail
        fill_const(16'h0000); script[1] = 16'h0060; script[3] = 16'h0040;
        run_poll(1, 1, 20'h0_0400, 0);
        // R6 toggling with timeout, stopped in confirmation -> pass
        fill_const(16'h0000); script[1] = 16'h0060; run_poll(1, 1, 20'h0_0500, 0);
        for (int n = 0; n < 60; n++) begin
          bit e, m;
          e = $urandom; m = $urandom;
          fill_rand(e);
          run_poll(m, e, AW'($urandom), (n % 4) == 0);
        end
      end
      begin
        repeat (100000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule